// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block sits between a set of device interrupt lines and the CPUs of a multi-core system. For every device it keeps a routing entry that names a target CPU and an interrupt vector, plus a small control word with a mask bit and a pending bit. Software programs both through a simple register port. The port takes a request in one cycle and returns the response registered in the next cycle.

When a device pulses its interrupt line and its entry is unmasked, the block accepts the event. It marks the entry pending, re-masks it, and issues a single-cycle post carrying the stored CPU id and vector toward the CPU-side interrupt logic. The source then stays quiet until software unmasks it again. Software acknowledges an interrupt by writing a dedicated clear bit in the control word. Only one post leaves per cycle. Events that arrive together are queued inside the block and released lowest device index first.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry reads as masked (control word 0x4), not pending, routed to CPU 0 with vector 0, and no post is issued.
- R2: The routing word of device i is at byte offset 8*i. A write stores data bits 12:8 as the CPU id and bits 5:0 as the vector. A read returns them in the same positions, with all other bits zero.
- R3: The control word of device i is at byte offset 8*(NUM_DEV+i). A read returns the mask in bit 2 and pending in bit 0. A write loads the mask from data bit 2, clears pending when data bit 1 is 1, and ignores data bit 0.
- R4: An interrupt pulse on a masked device is dropped: no post, and mask and pending are unchanged.
- R5: A pulse on an unmasked device sets mask and pending. In the cycle after the edge that samples the pulse, it raises post_valid for one cycle with that entry's CPU id and vector.
- R6: At most one post is issued per cycle. Simultaneous accepted events are posted lowest device index first, one per cycle, and none is lost.
- R7: When a control write and an accepted pulse hit the same entry in the same cycle, pending ends set even if the write asks to clear it, and the mask takes the written bit 2 value.
- R8: Every request is answered by rsp_valid in the following cycle, with read data valid in that cycle.
- R9: An access at an offset of 16*NUM_DEV or above returns read data zero with rsp_err high. A write there changes no entry.
- R10: A second pulse after acceptance posts nothing until software clears the mask. After the mask is cleared, the next pulse posts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Access hit an unmapped offset |
| dev_irq | input | NUM_DEV | Device interrupt pulses, one bit per device |
| post_valid | output | 1 | Single-cycle interrupt post |
| post_cpu | output | 5 | Target CPU of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
Two functions can meet on one entry in the same cycle: a software control write and a device pulse. The bench provokes this by driving a control write carrying the clear bit and a zero mask on the same clock as that device's interrupt pulse. It then judges the outcome in two ways. The scoreboard must see the post, and a read-back must show pending set with the mask cleared. Simultaneous pulses on several devices are also compared against an expected post order.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int CPU_W        = 5;
  localparam int VEC_W        = 6;
  localparam int CPU_LSB      = 8;
  localparam int CTL_MASK_BIT = 2;
  localparam int CTL_CLR_BIT  = 1;

  typedef struct packed {
    logic [CPU_W-1:0] cpu;
    logic [VEC_W-1:0] vec;
  } route_t;

  typedef enum logic [1:0] {
    KIND_ROUTE = 2'd0,
    KIND_CTRL  = 2'd1,
    KIND_NONE  = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] region;

  always_comb begin
    region = addr >> (IDX_W + 3);
    idx    = addr[IDX_W+2:3];
    if (region == ADDR_W'(0))      kind = KIND_ROUTE;
    else if (region == ADDR_W'(1)) kind = KIND_CTRL;
    else                           kind = KIND_NONE;
  end
endmodule

// File: rtl/irq_dev_entry.sv
module irq_dev_entry
  import irq_route_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   route_we,
  input  logic   ctrl_we,
  input  route_t wr_route,
  input  logic   wr_mask,
  input  logic   wr_clr,
  input  logic   irq,
  output route_t route,
  output logic   mask,
  output logic   pend,
  output logic   accept
);
  route_t route_q, route_d;
  logic   mask_q, mask_d, pend_q, pend_d;
  logic   state_en;

  always_comb begin
    accept   = irq & ~mask_q;
    route_d  = wr_route;
    state_en = ctrl_we | accept;
    if (ctrl_we)     mask_d = wr_mask;
    else             mask_d = 1'b1;
    if (accept)      pend_d = 1'b1;
    else if (wr_clr) pend_d = 1'b0;
    else             pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      mask_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (route_we) route_q <= route_d;
      if (state_en) begin
        mask_q <= mask_d;
        pend_q <= pend_d;
      end
    end
  end

  assign route = route_q;
  assign mask  = mask_q;
  assign pend  = pend_q;
endmodule

// File: rtl/irq_post_arb.sv
module irq_post_arb
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DEV-1:0] accept,
  input  route_t             routes [NUM_DEV],
  output logic               post_valid,
  output route_t             post_route
);
  logic [NUM_DEV-1:0] held_q, held_d, req, grant;
  logic [IDX_W-1:0]   sel;
  logic               any_req;
  logic               valid_q;
  route_t             route_q;

  always_comb begin
    req     = held_q | accept;
    any_req = |req;
    sel     = '0;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (req[i]) sel = IDX_W'(i);
    end
    grant  = any_req ? (NUM_DEV'(1) << sel) : '0;
    held_d = req & ~grant;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      valid_q <= 1'b0;
      route_q <= '0;
    end else begin
      held_q  <= held_d;
      valid_q <= any_req;
      if (any_req) route_q <= routes[sel];
    end
  end

  assign post_valid = valid_q;
  assign post_route = route_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  input  logic [NUM_DEV-1:0] dev_irq,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec
);
  localparam int IDX_W = $clog2(NUM_DEV);

  logic [1:0]         rst_pipe;
  logic               rst_n_s;
  reg_kind_e          kind;
  logic [IDX_W-1:0]   idx;
  route_t             wr_route;
  route_t             routes [NUM_DEV];
  route_t             post_route;
  logic [NUM_DEV-1:0] route_we, ctrl_we, mask_vec, pend_vec, accept_vec;
  logic [DATA_W-1:0]  rdata_d, rdata_q;
  logic               valid_q, err_q, err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  irq_reg_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .kind(kind), .idx(idx)
  );

  assign wr_route.cpu = req_wdata[CPU_LSB +: CPU_W];
  assign wr_route.vec = req_wdata[VEC_W-1:0];

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign route_we[g] = req_valid & req_write & (kind == KIND_ROUTE) & (idx == IDX_W'(g));
    assign ctrl_we[g]  = req_valid & req_write & (kind == KIND_CTRL)  & (idx == IDX_W'(g));
    irq_dev_entry u_entry (
      .clk(clk), .rst_n(rst_n_s),
      .route_we(route_we[g]), .ctrl_we(ctrl_we[g]),
      .wr_route(wr_route),
      .wr_mask(req_wdata[CTL_MASK_BIT]),
      .wr_clr(ctrl_we[g] & req_wdata[CTL_CLR_BIT]),
      .irq(dev_irq[g]),
      .route(routes[g]), .mask(mask_vec[g]), .pend(pend_vec[g]),
      .accept(accept_vec[g])
    );
  end

  irq_post_arb #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n_s), .accept(accept_vec), .routes(routes),
    .post_valid(post_valid), .post_route(post_route)
  );

  always_comb begin
    rdata_d = '0;
    err_d   = req_valid & (kind == KIND_NONE);
    if (req_valid && !req_write) begin
      case (kind)
        KIND_ROUTE: rdata_d = DATA_W'({routes[idx].cpu, 2'b00, routes[idx].vec});
        KIND_CTRL:  rdata_d = DATA_W'({mask_vec[idx], 1'b0, pend_vec[idx]});
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      valid_q <= req_valid;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;
  assign post_cpu  = post_route.cpu;
  assign post_vec  = post_route.vec;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_DEV = 8,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic [NUM_DEV-1:0] dev_irq,
  input logic [NUM_DEV-1:0] mask_vec,
  input logic [NUM_DEV-1:0] pend_vec,
  input logic [NUM_DEV-1:0] ctrl_we,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_rdata
);
  // R8: every request is answered next cycle
  p_rsp_next_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_valid |=> rsp_valid);

  // R9: unmapped accesses return zero data
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> (rsp_rdata == '0));

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_chk
    // R4: masked pulse leaves the entry untouched
    p_masked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
      (mask_vec[g] && dev_irq[g] && !ctrl_we[g]) |=> (mask_vec[g] && $stable(pend_vec[g])));

    // R5: accepted pulse sets mask and pending
    p_accept_sets_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
      (!mask_vec[g] && dev_irq[g] && !ctrl_we[g]) |=> (mask_vec[g] && pend_vec[g]));

    // R7: pending only rises from a device pulse, even against a clear
    p_pend_source_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
      $rose(pend_vec[g]) |-> $past(dev_irq[g]));
  end
endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .dev_irq(dev_irq), .mask_vec(mask_vec),
  .pend_vec(pend_vec), .ctrl_we(ctrl_we), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;
  localparam int NUM_DEV = 8;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 64;

  typedef struct {
    logic [4:0] cpu;
    logic [5:0] vec;
    string      tag;
  } post_exp_t;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [DATA_W-1:0]  req_wdata = '0;
  logic               rsp_valid, rsp_err, post_valid;
  logic [DATA_W-1:0]  rsp_rdata;
  logic [NUM_DEV-1:0] dev_irq = '0;
  logic [4:0]         post_cpu;
  logic [5:0]         post_vec;

  int        n_tests = 0, n_fail = 0;
  bit        mon_on = 1'b0;
  post_exp_t exp_q[$];

  always #2.5 clk = ~clk;

  irq_route_ctrl #(.NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .dev_irq(dev_irq),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec)
  );

  function automatic logic [ADDR_W-1:0] route_off(int i);
    return ADDR_W'(8 * i);
  endfunction
  function automatic logic [ADDR_W-1:0] ctrl_off(int i);
    return ADDR_W'(8 * (NUM_DEV + i));
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on && post_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4/R10: actual unexpected post cpu %0d vec %0d expected none", post_cpu, post_vec);
      end else begin
        post_exp_t e;
        e = exp_q.pop_front();
        if (post_cpu !== e.cpu || post_vec !== e.vec) begin
          n_fail++;
          $display("FAIL %s: actual cpu %0d vec %0d expected cpu %0d vec %0d",
                   e.tag, post_cpu, post_vec, e.cpu, e.vec);
        end
      end
    end
  end

  task automatic expect_post(logic [4:0] cpu, logic [5:0] vec, string tag);
    post_exp_t e;
    e.cpu = cpu; e.vec = vec; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp, logic exp_err, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R8 rsp_valid"}, 64'(rsp_valid), 64'd1);
    check(tag, rsp_rdata, exp);
    check({tag, " err"}, 64'(rsp_err), 64'(exp_err));
  endtask

  task automatic pulse(logic [NUM_DEV-1:0] v);
    @(negedge clk);
    dev_irq = v;
    @(negedge clk);
    dev_irq = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    idle(3);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1 reset state
    check("R1 no post", 64'(post_valid), 64'd0);
    bus_read(route_off(0), 64'h0, 1'b0, "R1 route0");
    bus_read(ctrl_off(0), 64'h4, 1'b0, "R1 ctrl0");
    bus_read(ctrl_off(NUM_DEV-1), 64'h4, 1'b0, "R1 ctrl last");

    // R2 routing word with junk bits
    bus_write(route_off(3), 64'hDEAD_0000_0000_FAEB);
    bus_read(route_off(3), 64'h1A2B, 1'b0, "R2 route3");

    // R4 masked pulse dropped
    pulse(8'b0000_1000);
    idle(2);
    bus_read(ctrl_off(3), 64'h4, 1'b0, "R4 ctrl3");

    // R3 control writes
    bus_write(ctrl_off(3), 64'h0);
    bus_read(ctrl_off(3), 64'h0, 1'b0, "R3 unmask");
    bus_write(ctrl_off(3), 64'h1);
    bus_read(ctrl_off(3), 64'h0, 1'b0, "R3 bit0 ignored");

    // R5 accept and post timing
    expect_post(5'h1A, 6'h2B, "R5");
    @(negedge clk); dev_irq = 8'b0000_1000;
    @(negedge clk); dev_irq = '0;
    check("R5 post_valid", 64'(post_valid), 64'd1);
    @(negedge clk);
    check("R5 single cycle", 64'(post_valid), 64'd0);
    bus_read(ctrl_off(3), 64'h5, 1'b0, "R5 ctrl3");

    // R10 fire once until unmasked
    pulse(8'b0000_1000);
    idle(2);
    bus_read(ctrl_off(3), 64'h5, 1'b0, "R10 still set");
    bus_write(ctrl_off(3), 64'h2);
    bus_read(ctrl_off(3), 64'h0, 1'b0, "R10 unmask clear");
    expect_post(5'h1A, 6'h2B, "R10");
    pulse(8'b0000_1000);
    idle(2);
    bus_read(ctrl_off(3), 64'h5, 1'b0, "R10 reposted");

    // R3 clear while keeping mask
    bus_write(ctrl_off(3), 64'h6);
    bus_read(ctrl_off(3), 64'h4, 1'b0, "R3 clear keep mask");

    // R6 simultaneous pulses, lowest index first
    bus_write(route_off(1), 64'h0311);
    bus_write(route_off(4), 64'h1E22);
    bus_write(route_off(6), 64'h0C3F);
    bus_write(ctrl_off(1), 64'h0);
    bus_write(ctrl_off(4), 64'h0);
    bus_write(ctrl_off(6), 64'h0);
    expect_post(5'h03, 6'h11, "R6 first");
    expect_post(5'h1E, 6'h22, "R6 second");
    expect_post(5'h0C, 6'h3F, "R6 third");
    pulse(8'b0101_0010);
    idle(5);
    check("R6 all posted", 64'(exp_q.size()), 64'd0);

    // R7 same-cycle control write and pulse
    bus_write(route_off(2), 64'h0715);
    bus_write(ctrl_off(2), 64'h0);
    expect_post(5'h07, 6'h15, "R7");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = ctrl_off(2); req_wdata = 64'h2;
    dev_irq = 8'b0000_0100;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; dev_irq = '0;
    idle(2);
    bus_read(ctrl_off(2), 64'h1, 1'b0, "R7 pend wins mask written");

    // R9 unmapped offsets
    bus_read(8'h80, 64'h0, 1'b1, "R9 read unmapped");
    bus_write(8'hF8, '1);
    bus_write(8'hB8, '1);
    bus_read(route_off(7), 64'h0, 1'b0, "R9 route7 untouched");
    bus_read(ctrl_off(7), 64'h4, 1'b0, "R9 ctrl7 untouched");

    idle(4);
    check("R6 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule